// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous, pipelined static memory that shares one data bus between reads and writes. Any mix of reads and writes may be issued on consecutive enabled clocks with no idle cycles. Address and control inputs are captured at a rising edge. The data phase of an operation falls two enabled clocks later. A read returns its word through an output register. A write takes its word from the shared data input in that same phase. Because both kinds of operation keep the same phase offset, the bus never needs a turnaround cycle.

The block keeps a write address in two internal stages until the data for that write arrives. A read that targets a write whose data has not yet reached the array is served from that write's data, merged byte by byte. The word is split into byte lanes, each with its own write select. A load cycle can open a four-beat burst. Later continue cycles step the two low address bits in linear or interleaved order. A clock enable freezes the whole pipeline. An asynchronous output enable gates only the output-valid flag. The array depth, lane width and lane count are parameters.

Top module: `zt_sram`

## Requirements
- R1: The word for a read whose address is captured at an enabled edge appears on `rdata`, with `rd_valid` high, right after the second enabled edge that follows. Disabled edges in between do not count.
- R2: Reads and writes may be issued on every enabled clock in any order with no idle cycles. Each read returns the word as it stands after every earlier-issued write.
- R3: At a rising edge where `clk_en` is low, no internal state changes. `rdata` and `rd_valid` hold their values, and `wdata` is not sampled.
- R4: `byte_wr[l]` enables writing bits `[9l+8:9l]` of the word (lane 0 is the low 9 bits, lane 1 the high 9 bits). A lane whose select is 0 keeps its old contents. A write with `byte_wr` = 00 changes nothing.
- R5: A load cycle (`adv` = 0) selects the device only when `cs_a`, `cs_b` and `cs_c` are all 1. Otherwise the cycle is a deselect and the array is neither read nor written.
- R6: `rd_valid` is 0 after the data-phase edge of a write or a deselect, so the block never claims the bus during those phases.
- R7: With `adv` = 1 the cycle continues the last load. It repeats the load's operation type and upper address bits and ignores `wr_en`, the chip enables, `addr` and `burst_mode`. On beat n after the load (n = 1, 2, 3, wrapping mod 4) the low two address bits become base+n mod 4 when the load had `burst_mode` = 0 (linear), or base XOR n when it had `burst_mode` = 1 (interleaved). `byte_wr` is taken from the current cycle.
- R8: A read issued on the clock right after a write to the same address returns that write's data in the selected lanes and the older contents in the other lanes.
- R9: `out_en` only gates `rd_valid`, without a clock. When `out_en` is 0, `rd_valid` is 0. `rdata` and the internal state are unaffected.
- R10: The data for a write is sampled from `wdata` at the second enabled edge after the edge that captured its address.
- R11: Reset (synchronous, active high) clears `rd_valid` and `rdata` to 0 and leaves no burst open, so a continue cycle right after reset acts as a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; 0 freezes the pipeline |
| addr | input | ADDR_W | Word address for load cycles |
| cs_a | input | 1 | Chip enable, active high |
| cs_b | input | 1 | Chip enable, active high |
| cs_c | input | 1 | Chip enable, active high |
| wr_en | input | 1 | 1 = write, 0 = read on a load cycle |
| byte_wr | input | LANES | Per-lane write selects |
| adv | input | 1 | 1 = continue burst, 0 = load new address |
| burst_mode | input | 1 | 0 = linear, 1 = interleaved, sampled at load |
| wdata | input | LANE_W*LANES | Write data, sampled in the data phase |
| out_en | input | 1 | Asynchronous gate for `rd_valid` |
| rdata | output | LANE_W*LANES | Registered read data |
| rd_valid | output | 1 | Read data phase flag, gated by `out_en` |

## Verification
On every cycle the assertions check several rules. Nothing moves while the clock enable is low. A load with any chip enable low becomes a deselect. The valid flag follows a read data phase and drops after a write or deselect phase. A burst continuation keeps its operation type and upper address bits. Only the bench scenarios can show the data values themselves. These include the byte-merged forwarding of a pending write, the two-enabled-clock latency across disabled gaps, the delayed sampling of write data, and the exact linear and interleaved beat order with wrap.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int ADDR_W = 8,
  parameter int WIDTH  = 9
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  // read-first single clock memory, block RAM friendly
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic              sel,
  input  logic              wr,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);
  op_e                op_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic               mode_q;
  logic [BURST_W-1:0] lo;

  always_comb begin
    lo = mode_q ? (base_q[BURST_W-1:0] ^ cnt_q) : (base_q[BURST_W-1:0] + cnt_q);
    if (load) begin
      cmd_op   = sel ? (wr ? OP_WR : OP_RD) : OP_IDLE;
      cmd_addr = addr;
    end else begin
      cmd_op   = op_q;
      cmd_addr = {base_q[ADDR_W-1:BURST_W], lo};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (en) begin
      if (load) begin
        op_q   <= cmd_op;
        base_q <= addr;
        cnt_q  <= BURST_W'(1);
        mode_q <= mode;
      end else begin
        cnt_q  <= cnt_q + BURST_W'(1);
      end
    end
  end

  // R3: burst state frozen while the clock enable is low
  p_burst_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cnt_q) && $stable(op_q) && $stable(base_q)));
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clk_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     cs_a,
  input  logic                     cs_b,
  input  logic                     cs_c,
  input  logic                     wr_en,
  input  logic [LANES-1:0]         byte_wr,
  input  logic                     adv,
  input  logic                     burst_mode,
  input  logic [LANE_W*LANES-1:0]  wdata,
  input  logic                     out_en,
  output logic [LANE_W*LANES-1:0]  rdata,
  output logic                     rd_valid
);
  localparam int DATA_W = LANE_W * LANES;

  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;

  // stage 1: captured command; stage 2: waiting for its data phase
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_be, s2_be;

  logic              fwd_hit;
  logic [LANES-1:0]  fwd_be;
  logic [DATA_W-1:0] fwd_d;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] merged;
  logic              rd_q;

  sram_burst_ctl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk      (clk),
    .rst      (rst),
    .en       (clk_en),
    .load     (!adv),
    .sel      (cs_a && cs_b && cs_c),
    .wr       (wr_en),
    .mode     (burst_mode),
    .addr     (addr),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_lane #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_lane (
      .clk   (clk),
      .en    (clk_en),
      .we    ((s2_op == OP_WR) && s2_be[l]),
      .waddr (s2_addr),
      .wdata (wdata[l*LANE_W +: LANE_W]),
      .raddr (s1_addr),
      .rdata (mem_q[l*LANE_W +: LANE_W])
    );
    assign merged[l*LANE_W +: LANE_W] = (fwd_hit && fwd_be[l]) ?
        fwd_d[l*LANE_W +: LANE_W] : mem_q[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_IDLE;
      s2_op   <= OP_IDLE;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_be   <= '0;
      s2_be   <= '0;
      fwd_hit <= 1'b0;
      fwd_be  <= '0;
      fwd_d   <= '0;
      rd_q    <= 1'b0;
      rdata   <= '0;
    end else if (clk_en) begin
      s1_op   <= cmd_op;
      s1_addr <= cmd_addr;
      s1_be   <= byte_wr;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      // the write in stage 2 lands in the array on the same edge the
      // read in stage 1 samples it, so its data is kept for a merge
      fwd_hit <= (s2_op == OP_WR) && (s1_op == OP_RD) && (s2_addr == s1_addr);
      fwd_be  <= s2_be;
      fwd_d   <= wdata;
      rd_q    <= (s2_op == OP_RD);
      if (s2_op == OP_RD) rdata <= merged;
    end
  end

  assign rd_valid = rd_q && out_en;

  // R3: output register and flag frozen while the clock enable is low
  p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(rdata) && $stable(rd_q)));

  // R5: a load with any chip enable low becomes a deselect
  p_desel_r5: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !adv && !(cs_a && cs_b && cs_c)) |=> (s1_op == OP_IDLE));

  // R6: write or deselect data phase leaves the bus unclaimed
  p_nodrive_r6: assert property (@(posedge clk) disable iff (rst)
    (clk_en && (s2_op != OP_RD)) |=> !rd_q);

  // R1: a read data phase raises the flag
  p_rd_phase_r1: assert property (@(posedge clk) disable iff (rst)
    (clk_en && (s2_op == OP_RD)) |=> rd_q);

  // R7: continuation repeats the operation and keeps the upper address
  p_burst_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv) |=> ((s1_op == $past(s1_op)) &&
      (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W]))));
endmodule

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
  localparam logic [1:0] K_ID = 2'd0;
  localparam logic [1:0] K_RD = 2'd1;
  localparam logic [1:0] K_WR = 2'd2;
  localparam logic [17:0] JUNK = 18'h1F0F0;
  localparam int NMAIN = 18;

  // {kind, addr, byte selects, data}
  localparam logic [29:0] MAIN_TBL [NMAIN] = '{
    {K_WR, 8'h10, 2'b11, 18'h12345},
    {K_WR, 8'h11, 2'b11, 18'h0ABCD},
    {K_RD, 8'h10, 2'b00, 18'h00000},
    {K_WR, 8'h10, 2'b01, 18'h3FFFF},
    {K_RD, 8'h10, 2'b00, 18'h00000},
    {K_RD, 8'h11, 2'b00, 18'h00000},
    {K_WR, 8'h12, 2'b11, 18'h15555},
    {K_ID, 8'h00, 2'b00, 18'h00000},
    {K_WR, 8'h12, 2'b10, 18'h2AAAA},
    {K_RD, 8'h12, 2'b00, 18'h00000},
    {K_RD, 8'h10, 2'b00, 18'h00000},
    {K_WR, 8'h11, 2'b11, 18'h00F0F},
    {K_RD, 8'h11, 2'b00, 18'h00000},
    {K_WR, 8'h12, 2'b00, 18'h3FFFF},
    {K_RD, 8'h12, 2'b00, 18'h00000},
    {K_WR, 8'h12, 2'b11, 18'h01111},
    {K_RD, 8'h12, 2'b00, 18'h00000},
    {K_RD, 8'h10, 2'b00, 18'h00000}
  };

  logic        clk = 1'b0;
  logic        rst, clk_en, cs_a, cs_b, cs_c, wr_en, adv, burst_mode, out_en;
  logic [7:0]  addr;
  logic [1:0]  byte_wr;
  logic [17:0] wdata, rdata;
  logic        rd_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [17:0] mem_m [256];
  int          n_seq = 0;
  logic [1:0]  k_a [32];
  logic        adv_a [32];
  logic        mode_a [32];
  logic [2:0]  cs_v [32];
  logic        wrd_a [32];
  logic [7:0]  addr_a [32];
  logic [7:0]  eff_a [32];
  logic [1:0]  be_a [32];
  logic [17:0] d_a [32];
  logic [17:0] exp_a [32];
  string       tag_a [32];

  zt_sram dut_i (
    .clk(clk), .rst(rst), .clk_en(clk_en), .addr(addr),
    .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c), .wr_en(wr_en),
    .byte_wr(byte_wr), .adv(adv), .burst_mode(burst_mode),
    .wdata(wdata), .out_en(out_en), .rdata(rdata), .rd_valid(rd_valid)
  );

  always #4 clk = ~clk;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string tag, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic add(input logic [1:0] k, input logic a, input logic m,
                     input logic [2:0] cs, input logic wrd, input logic [7:0] ad,
                     input logic [7:0] ef, input logic [1:0] be,
                     input logic [17:0] d, input string tag);
    k_a[n_seq] = k;   adv_a[n_seq] = a;   mode_a[n_seq] = m;
    cs_v[n_seq] = cs; wrd_a[n_seq] = wrd; addr_a[n_seq] = ad;
    eff_a[n_seq] = ef; be_a[n_seq] = be;  d_a[n_seq] = d;
    tag_a[n_seq] = tag;
    n_seq++;
  endtask

  task automatic drive_idle();
    clk_en = 1'b1; cs_a = 1'b0; cs_b = 1'b0; cs_c = 1'b0;
    wr_en = 1'b0; byte_wr = 2'b00; adv = 1'b0; burst_mode = 1'b0;
    addr = 8'h00;
  endtask

  task automatic drive_slot(input int t);
    clk_en = 1'b1;
    addr = addr_a[t];
    {cs_a, cs_b, cs_c} = cs_v[t];
    wr_en = wrd_a[t];
    byte_wr = be_a[t];
    adv = adv_a[t];
    burst_mode = mode_a[t];
    // sequential model: every earlier-issued write is visible
    if (k_a[t] == K_RD) exp_a[t] = mem_m[eff_a[t]];
    if (k_a[t] == K_WR) begin
      if (be_a[t][0]) mem_m[eff_a[t]][8:0]  = d_a[t][8:0];
      if (be_a[t][1]) mem_m[eff_a[t]][17:9] = d_a[t][17:9];
    end
  endtask

  task automatic check_slot(input int s);
    if (k_a[s] == K_RD) chk(tag_a[s], {rd_valid, rdata}, {1'b1, exp_a[s]});
    else                chk(tag_a[s], {rd_valid, 18'h0}, 19'h0);
  endtask

  // issue slot t, put data of slot t-2 on the bus, check slot t-3
  task automatic run_seq();
    for (int t = 0; t < n_seq + 3; t++) begin
      @(negedge clk);
      if (t >= 3) check_slot(t - 3);
      if (t < n_seq) drive_slot(t); else drive_idle();
      if (t >= 2 && t - 2 < n_seq && k_a[t-2] == K_WR) wdata = d_a[t-2];
      else wdata = JUNK;
    end
    n_seq = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; out_en = 1'b1; wdata = JUNK;
    drive_idle();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R11 reset state", {rd_valid, rdata}, 19'h0);
    rst = 1'b0;

    // R11: continue right after reset is a deselect
    add(K_ID, 1'b1, 1'b0, 3'b111, 1'b0, 8'h10, 8'h10, 2'b11, 18'h0, "R11");
    run_seq();

    // R2, R8, R4: mixed back-to-back table
    for (int i = 0; i < NMAIN; i++) begin
      logic [29:0] e;
      string tg;
      e = MAIN_TBL[i];
      if (e[29:28] != K_RD) tg = "R6";
      else if (i == 4 || i == 9 || i == 12) tg = "R8";
      else if (i == 14) tg = "R4";
      else tg = "R2";
      add(e[29:28], 1'b0, 1'b0, (e[29:28] == K_ID) ? 3'b110 : 3'b111,
          e[29:28] == K_WR, e[27:20], e[27:20], e[19:18], e[17:0], tg);
    end
    run_seq();

    // R5: one chip enable low at a time, then read back
    add(K_ID, 1'b0, 1'b0, 3'b011, 1'b1, 8'h10, 8'h10, 2'b11, 18'h0, "R5");
    add(K_ID, 1'b0, 1'b0, 3'b101, 1'b1, 8'h10, 8'h10, 2'b11, 18'h0, "R5");
    add(K_ID, 1'b0, 1'b0, 3'b110, 1'b1, 8'h10, 8'h10, 2'b11, 18'h0, "R5");
    add(K_RD, 1'b0, 1'b0, 3'b111, 1'b0, 8'h10, 8'h10, 2'b00, 18'h0, "R5");
    run_seq();

    // R7: linear write burst from 41, interleaved read from 41, linear read from 43
    add(K_WR, 1'b0, 1'b0, 3'b111, 1'b1, 8'h41, 8'h41, 2'b11, 18'h0A0A0, "R7");
    add(K_WR, 1'b1, 1'b1, 3'b000, 1'b0, 8'hFF, 8'h42, 2'b11, 18'h1B1B1, "R7");
    add(K_WR, 1'b1, 1'b1, 3'b000, 1'b0, 8'hFF, 8'h43, 2'b11, 18'h2C2C2, "R7");
    add(K_WR, 1'b1, 1'b1, 3'b000, 1'b0, 8'hFF, 8'h40, 2'b11, 18'h3D3D3, "R7");
    add(K_RD, 1'b0, 1'b1, 3'b111, 1'b0, 8'h41, 8'h41, 2'b00, 18'h0, "R7");
    add(K_RD, 1'b1, 1'b0, 3'b000, 1'b1, 8'h00, 8'h40, 2'b00, 18'h0, "R7");
    add(K_RD, 1'b1, 1'b0, 3'b000, 1'b1, 8'h00, 8'h43, 2'b00, 18'h0, "R7");
    add(K_RD, 1'b1, 1'b0, 3'b000, 1'b1, 8'h00, 8'h42, 2'b00, 18'h0, "R7");
    add(K_RD, 1'b0, 1'b0, 3'b111, 1'b0, 8'h43, 8'h43, 2'b00, 18'h0, "R7");
    add(K_RD, 1'b1, 1'b1, 3'b000, 1'b1, 8'h00, 8'h40, 2'b00, 18'h0, "R7");
    add(K_RD, 1'b1, 1'b1, 3'b000, 1'b1, 8'h00, 8'h41, 2'b00, 18'h0, "R7");
    add(K_RD, 1'b1, 1'b1, 3'b000, 1'b1, 8'h00, 8'h42, 2'b00, 18'h0, "R7");
    run_seq();

    // R10, R3: write data taken at the second enabled edge despite gaps
    @(negedge clk);
    drive_idle(); addr = 8'h55; {cs_a, cs_b, cs_c} = 3'b111;
    wr_en = 1'b1; byte_wr = 2'b11; wdata = JUNK;
    @(negedge clk);
    drive_idle(); wdata = JUNK;
    @(negedge clk);
    clk_en = 1'b0; wdata = 18'h00001;
    @(negedge clk);
    wdata = 18'h00002;
    @(negedge clk);
    clk_en = 1'b1; wdata = 18'h2D2D2;
    @(negedge clk);
    wdata = JUNK;
    mem_m[8'h55] = 18'h2D2D2;
    add(K_RD, 1'b0, 1'b0, 3'b111, 1'b0, 8'h55, 8'h55, 2'b00, 18'h0, "R10");
    run_seq();

    // R1, R3: read latency counted in enabled edges only
    @(negedge clk);
    drive_idle(); addr = 8'h11; {cs_a, cs_b, cs_c} = 3'b111;
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    chk("R1 not yet after one edge", {rd_valid, 18'h0}, 19'h0);
    clk_en = 1'b0; addr = 8'h10; {cs_a, cs_b, cs_c} = 3'b111;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 gap holds pipeline", {rd_valid, 18'h0}, 19'h0);
    end
    drive_idle();
    @(negedge clk);
    chk("R1 read after two enabled edges", {rd_valid, rdata}, {1'b1, mem_m[8'h11]});
    clk_en = 1'b0; {cs_a, cs_b, cs_c} = 3'b111; addr = 8'h10;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 output held", {rd_valid, rdata}, {1'b1, mem_m[8'h11]});
    end

    // R9: output enable gates the flag only
    out_en = 1'b0;
    #1;
    chk("R9 flag gated", {rd_valid, rdata}, {1'b0, mem_m[8'h11]});
    @(negedge clk);
    out_en = 1'b1;
    #1;
    chk("R9 flag restored", {rd_valid, rdata}, {1'b1, mem_m[8'h11]});
    drive_idle();
    @(negedge clk);
    @(negedge clk);
    chk("R6 idle after flush", {rd_valid, 18'h0}, 19'h0);

    done = 1;
    report();
    $finish;
  end
endmodule